// File: doc/BRIEF.md
# FIFO Level Interrupt Controller

This block holds the receive and transmit byte queues that sit next to a serial shift engine and turns their fill levels into interrupt requests. Software pushes transmit bytes and pops receive bytes through simple strobes. The shift engine does the opposite on the other side of each queue. Both fill counts are packed into one status word.

Three sticky status flags record the conditions that software cares about. The receive queue has reached three quarters of its capacity. The transmit queue has drained to one quarter or less. The engine has signalled the end of a transfer. Each flag sets whether or not it is enabled. An enable word selects which flags drive the single interrupt line. Software clears a flag by writing a 1 at its position. The two level flags are re-armed on every cycle that their condition still holds, so a clear only takes effect once software has drained or refilled the queue. Each queue also has its own flush strobe, which empties it.

Top module: `fifo_level_irq`

## Requirements
- R1: While reset is held, the fill-count word, the status word and the enable word all read zero, and the interrupt line is low.
- R2: Each accepted push raises the fill count of its queue by one, and each accepted pop lowers it by one. Bytes leave in the order they entered, and the read data shows the oldest byte before it is popped. The receive count sits at bits [6:0] of the fill-count word and the transmit count at bits [22:16].
- R3: A push into a full queue (64 bytes) or a pop from an empty queue is ignored and leaves the count unchanged.
- R4: A flush strobe empties its own queue on the next edge, takes priority over a push or pop in the same cycle, and leaves the other queue untouched.
- R5: Status bit 4 sets on the clock edge after the receive count is 48 or more.
- R6: Status bit 12 sets on the clock edge after the transmit count is 16 or less.
- R7: A transfer-done pulse sets status bit 16 on the next edge.
- R8: A status write clears each flag whose data bit is 1 and leaves flags with a 0 bit alone. A flag whose condition still holds on that edge stays set, so writing all ones clears every flag that is not being re-armed.
- R9: Flags set even when they are disabled. The enable word keeps only bits 4, 12 and 16, and other bits read zero. The interrupt line is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Software pushes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_rd | input | 1 | Engine pops the oldest transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte |
| rx_wr | input | 1 | Engine pushes a received byte |
| rx_wdata | input | 8 | Received byte to push |
| rx_rd | input | 1 | Software pops the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| tx_flush | input | 1 | Empty the transmit queue |
| rx_flush | input | 1 | Empty the receive queue |
| xfer_done | input | 1 | One-cycle pulse from the engine at the end of a transfer |
| en_wr | input | 1 | Write strobe for the enable word |
| en_wdata | input | 32 | Data for the enable word |
| sts_wr | input | 1 | Write strobe for the status word (write 1 to clear) |
| sts_wdata | input | 32 | Clear mask for the status word |
| fifo_sta | output | 32 | Packed fill counts of both queues |
| en_word | output | 32 | Current enable word |
| sts_word | output | 32 | Current status flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `xfer_done` is a one-cycle pulse and that the strobes are driven with clean values. They also assume that a status clear of the done flag never coincides with a new done pulse, because on that edge the set deliberately wins. The bench drives every strobe for exactly one cycle from the falling edge. It issues clear writes only on cycles with no done pulse. It watches the level flags only across edges where the bench itself knows the fill count, so the one-cycle lag between a count change and its flag is always part of the expected value.

// File: rtl/fifo_level_irq_pkg.sv
package fifo_level_irq_pkg;

  // Bit positions shared by the status and enable words
  localparam int RXHI_BIT  = 4;
  localparam int TXLO_BIT  = 12;
  localparam int DONE_BIT  = 16;
  localparam int NFLAG     = 3;

  // Field positions inside the packed fill-count word
  localparam int RXCNT_LSB = 0;
  localparam int TXCNT_LSB = 16;

  // Index of each flag inside the internal flag vector
  localparam int F_RXHI = 0;
  localparam int F_TXLO = 1;
  localparam int F_DONE = 2;

  // Receive queue has reached three quarters of capacity
  function automatic logic reach_high(input logic [31:0] cnt, input logic [31:0] depth);
    return (cnt * 32'd4) >= (depth * 32'd3);
  endfunction

  // Transmit queue holds at most one quarter of capacity
  function automatic logic reach_low(input logic [31:0] cnt, input logic [31:0] depth);
    return (cnt * 32'd4) <= depth;
  endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             push_ok,
  output logic             pop_ok
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full & ~flush;
  assign pop_ok  = pop & ~empty & ~flush;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  output logic [NFLAG-1:0] flags
);

  // One sticky bit per flag; a set on the same edge beats a clear
  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[gi] <= 1'b0;
      else        flags[gi] <= set_vec[gi] | (flags[gi] & ~clr_vec[gi]);
    end
  end

endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq
  import fifo_level_irq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic [WIDTH-1:0] tx_wdata,
  input  logic             tx_rd,
  output logic [WIDTH-1:0] tx_rdata,
  input  logic             rx_wr,
  input  logic [WIDTH-1:0] rx_wdata,
  input  logic             rx_rd,
  output logic [WIDTH-1:0] rx_rdata,
  input  logic             tx_flush,
  input  logic             rx_flush,
  input  logic             xfer_done,
  input  logic             en_wr,
  input  logic [31:0]      en_wdata,
  input  logic             sts_wr,
  input  logic [31:0]      sts_wdata,
  output logic [31:0]      fifo_sta,
  output logic [31:0]      en_word,
  output logic [31:0]      sts_word,
  output logic             irq
);

  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic             rx_hi_evt, tx_lo_evt;
  logic [NFLAG-1:0] set_vec, clr_vec, flags, en_q, en_d;
  logic             unused_wdata;

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_wr), .wdata(tx_wdata), .pop(tx_rd), .rdata(tx_rdata),
    .count(tx_cnt), .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_wr), .wdata(rx_wdata), .pop(rx_rd), .rdata(rx_rdata),
    .count(rx_cnt), .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  // Level events derived from the registered counts
  assign rx_hi_evt = reach_high(32'(rx_cnt), 32'(DEPTH));
  assign tx_lo_evt = reach_low(32'(tx_cnt), 32'(DEPTH));

  always_comb begin
    set_vec         = '0;
    set_vec[F_RXHI] = rx_hi_evt;
    set_vec[F_TXLO] = tx_lo_evt;
    set_vec[F_DONE] = xfer_done;
    clr_vec         = '0;
    en_d            = '0;
    if (sts_wr) begin
      clr_vec[F_RXHI] = sts_wdata[RXHI_BIT];
      clr_vec[F_TXLO] = sts_wdata[TXLO_BIT];
      clr_vec[F_DONE] = sts_wdata[DONE_BIT];
    end
    en_d[F_RXHI] = en_wdata[RXHI_BIT];
    en_d[F_TXLO] = en_wdata[TXLO_BIT];
    en_d[F_DONE] = en_wdata[DONE_BIT];
  end

  flag_bank #(.NFLAG(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  always_comb begin
    fifo_sta                      = '0;
    fifo_sta[RXCNT_LSB +: CW]     = rx_cnt;
    fifo_sta[TXCNT_LSB +: CW]     = tx_cnt;
    sts_word                      = '0;
    sts_word[RXHI_BIT]            = flags[F_RXHI];
    sts_word[TXLO_BIT]            = flags[F_TXLO];
    sts_word[DONE_BIT]            = flags[F_DONE];
    en_word                       = '0;
    en_word[RXHI_BIT]             = en_q[F_RXHI];
    en_word[TXLO_BIT]             = en_q[F_TXLO];
    en_word[DONE_BIT]             = en_q[F_DONE];
  end

  assign irq = |(flags & en_q);

  // Only three bits of each write word carry meaning
  assign unused_wdata = ^{en_wdata, sts_wdata, tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok};

endmodule

// File: rtl/fifo_level_irq_chk.sv
module fifo_level_irq_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          tx_wr,
  input logic          tx_rd,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic          rx_hi_evt,
  input logic          tx_lo_evt,
  input logic          xfer_done,
  input logic          sts_wr,
  input logic          sts_clr_done,
  input logic [31:0]   sts_word,
  input logic [31:0]   en_word,
  input logic          irq
);

  a_r3_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));

  a_r3_tx_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(DEPTH) && tx_wr && !tx_rd && !tx_flush) |=> tx_cnt == CW'(DEPTH));

  a_r4_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_cnt == '0);

  a_r5_rx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hi_evt |=> sts_word[4]);

  a_r6_tx_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lo_evt |=> sts_word[12]);

  a_r7_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts_word[16]);

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_clr_done && !xfer_done) |=> !sts_word[16]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_word == 32'd0) |-> !irq);

endmodule

bind fifo_level_irq fifo_level_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .tx_wr(tx_wr), .tx_rd(tx_rd), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .rx_hi_evt(rx_hi_evt), .tx_lo_evt(tx_lo_evt), .xfer_done(xfer_done),
  .sts_wr(sts_wr), .sts_clr_done(sts_wdata[16]), .sts_word(sts_word),
  .en_word(en_word), .irq(irq)
);

// File: tb/fifo_level_irq_tb.sv
module fifo_level_irq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0;
  logic [7:0]  tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic        tx_flush = 0, rx_flush = 0, xfer_done = 0;
  logic        en_wr = 0, sts_wr = 0;
  logic [31:0] en_wdata = 0, sts_wdata = 0;
  logic [31:0] fifo_sta, en_word, sts_word;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  fifo_level_irq u_dut (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_rd(tx_rd),
    .tx_rdata(tx_rdata), .rx_wr(rx_wr), .rx_wdata(rx_wdata), .rx_rd(rx_rd),
    .rx_rdata(rx_rdata), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .xfer_done(xfer_done), .en_wr(en_wr), .en_wdata(en_wdata), .sts_wr(sts_wr),
    .sts_wdata(sts_wdata), .fifo_sta(fifo_sta), .en_word(en_word),
    .sts_word(sts_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic rx_push(input logic [7:0] d); rx_wr = 1; rx_wdata = d; step(); rx_wr = 0; endtask
  task automatic tx_push(input logic [7:0] d); tx_wr = 1; tx_wdata = d; step(); tx_wr = 0; endtask
  task automatic rx_pop(); rx_rd = 1; step(); rx_rd = 0; endtask
  task automatic tx_pop(); tx_rd = 1; step(); tx_rd = 0; endtask
  task automatic flush_both(); rx_flush = 1; tx_flush = 1; step(); rx_flush = 0; tx_flush = 0; endtask
  task automatic clr(input logic [31:0] m); sts_wr = 1; sts_wdata = m; step(); sts_wr = 0; sts_wdata = 0; endtask
  task automatic set_en(input logic [31:0] m); en_wr = 1; en_wdata = m; step(); en_wr = 0; endtask
  task automatic done_pulse(); xfer_done = 1; step(); xfer_done = 0; endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1 fill word", fifo_sta, 32'h0);
    chk("R1 status", sts_word, 32'h0);
    chk("R1 enable", en_word, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1;
    step();
    chk("R6 tx low after reset", sts_word, 32'h0000_1000);
  endtask

  task automatic t_order();
    rx_push(8'hA5); rx_push(8'h3C); rx_push(8'hF0);
    chk("R2 rx count", fifo_sta, 32'd3);
    chk("R2 rx head0", {24'h0, rx_rdata}, 32'hA5); rx_pop();
    chk("R2 rx head1", {24'h0, rx_rdata}, 32'h3C); rx_pop();
    chk("R2 rx head2", {24'h0, rx_rdata}, 32'hF0); rx_pop();
    tx_push(8'h11); tx_push(8'h22);
    chk("R2 tx count field", fifo_sta, 32'h0002_0000);
    chk("R2 tx head", {24'h0, tx_rdata}, 32'h11);
    tx_pop(); tx_pop();
    chk("R2 both empty", fifo_sta, 32'h0);
  endtask

  task automatic t_rx_thresh();
    for (int i = 0; i < 47; i++) rx_push(8'(i));
    clr(32'h10);
    chk("R5 below 48 clear", {31'h0, sts_word[4]}, 32'h0);
    rx_push(8'd47);
    chk("R5 count 48", fifo_sta, 32'd48);
    chk("R5 flag lags one edge", {31'h0, sts_word[4]}, 32'h0);
    step();
    chk("R5 flag set", {31'h0, sts_word[4]}, 32'h1);
    clr(32'h10);
    chk("R8 rearmed while level holds", {31'h0, sts_word[4]}, 32'h1);
    rx_pop();
    clr(32'h10);
    chk("R8 cleared after drain", {31'h0, sts_word[4]}, 32'h0);
    rx_flush = 1; rx_wr = 1; rx_wdata = 8'h77; step(); rx_flush = 0; rx_wr = 0;
    chk("R4 flush beats push, tx untouched", fifo_sta, 32'h0);
  endtask

  task automatic t_tx_thresh();
    for (int i = 0; i < 17; i++) tx_push(8'(i));
    clr(32'h1000);
    chk("R6 cleared above 16", {31'h0, sts_word[12]}, 32'h0);
    tx_pop();
    chk("R6 count 16 flag lags", {31'h0, sts_word[12]}, 32'h0);
    step();
    chk("R6 flag set at 16", {31'h0, sts_word[12]}, 32'h1);
  endtask

  task automatic t_overflow();
    bit bad = 0;
    flush_both();
    for (int i = 0; i < 64; i++) tx_push(8'(i + 100));
    chk("R3 tx full count", fifo_sta, 32'h0040_0000);
    tx_push(8'hEE);
    chk("R3 push into full ignored", fifo_sta, 32'h0040_0000);
    for (int i = 0; i < 64; i++) begin
      if (tx_rdata !== 8'(i + 100)) bad = 1;
      tx_pop();
    end
    chk("R3 data intact after overflow", {31'h0, bad}, 32'h0);
    tx_pop(); rx_pop();
    chk("R3 pop from empty ignored", fifo_sta, 32'h0);
  endtask

  task automatic t_flush();
    for (int i = 0; i < 5; i++) rx_push(8'(i));
    for (int i = 0; i < 3; i++) tx_push(8'(i));
    rx_flush = 1; rx_rd = 1; step(); rx_flush = 0; rx_rd = 0;
    chk("R4 rx flushed, tx kept", fifo_sta, 32'h0003_0000);
  endtask

  task automatic t_irq();
    flush_both();
    for (int i = 0; i < 20; i++) tx_push(8'(i));
    clr(32'hFFFF_FFFF);
    chk("R8 all ones clears", sts_word, 32'h0);
    done_pulse();
    chk("R7 done flag", sts_word, 32'h0001_0000);
    chk("R9 masked flag no irq", {31'h0, irq}, 32'h0);
    clr(32'hFFFE_FFFF);
    chk("R8 zero bit keeps flag", sts_word, 32'h0001_0000);
    set_en(32'hFFFF_FFFF);
    chk("R9 enable keeps three bits", en_word, 32'h0001_1010);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    set_en(32'h0000_0010);
    chk("R9 irq masked off", {31'h0, irq}, 32'h0);
    set_en(32'h0001_0000);
    clr(32'h0001_0000);
    chk("R8 done cleared, irq low", {sts_word[31:1], irq}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_rx_thresh();
    t_tx_thresh();
    t_overflow();
    t_flush();
    t_irq();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule